// File: doc/BRIEF.md
# Memory Bitfield Span Sequencer

This block runs one bitfield operation on an operand held in byte-addressed, big-endian memory. A command gives a base byte address, a signed bit offset, a field width of 1 to 32 bits, an operation code and, for insertion, a source word. The block moves the address forward or back by whole bytes from the offset, keeps the remaining 0 to 7 bits as an offset inside the first byte, and works out how many bytes, from one to five, the field touches. Bit 7 of a byte is the first bit of that byte.

It fetches those bytes one at a time through a single-byte request/response port into a window aligned at the top. It then derives the field, the extract and find-first-one results and the N and Z flags. For set, clear, change and insert it stores the same bytes back in the same order. Every read is done before anything is written or committed. A fault on any beat ends the command with an error pulse, and the result and flags keep their previous values.

Back-pressure rules on the request channel: `mem_req_valid` stays high, with address, direction, write-intent and data held constant, until a cycle in which `mem_req_ready` is high. Only one beat is in flight at a time. The response is a single-cycle `mem_rsp_valid` pulse that the block always accepts. `start` is only taken while the block is idle.

Top module: `bfmem_seq`

## Requirements
- R1: The first byte accessed is at `base_i + (off_i >>> 3)`, with the arithmetic shift taken on the signed 32-bit offset. A negative offset therefore moves to lower addresses.
- R2: Each command issues exactly `(off_i[2:0] + W + 7) >> 3` read beats, where W = `wm1_i + 1`. The reads go to consecutive ascending addresses from the first byte.
- R3: The field is the W bits that start at bit `off_i[2:0]` of the first byte, counted from bit 7 downward and running on into the next bytes. For extract-unsigned (op 1), and for ops 0, 2, 4, 6 and 7, `result_o` is the field zero-extended, taken before any change.
- R4: Extract-signed (op 3) returns the field sign-extended from its top bit.
- R5: Find-first-one (op 5) returns `off_i` plus the number of zero bits ahead of the first one bit in the field. If the field is all zero it returns `off_i + W`.
- R6: `flag_n_o` is the top bit of the flagged value and `flag_z_o` is set when that value is zero. The flagged value is the field, except for insert, where it is the low W bits of `src_i`.
- R7: Set (op 6), clear (op 4) and change (op 2) force the field bits to one, to zero, or invert them. Other bits in the touched bytes are unchanged.
- R8: Insert (op 7) replaces the field with the low W bits of `src_i`.
- R9: Modifying ops write back exactly the bytes that were read, in ascending order, and only after all reads. Ops 0, 1, 3 and 5 issue no write beat.
- R10: A fault response ends the command with a one-cycle `error_o`, no `done_o`, no further beats, and unchanged `result_o`, `flag_n_o` and `flag_z_o`.
- R11: Read beats carry `mem_req_wint` high for modifying ops and low for the others, so a byte that cannot be written faults before anything is written.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its fields are held the next cycle.
- R13: A successful command ends with a one-cycle `done_o`. `result_o` and the flags are updated in that same cycle and held until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken when idle |
| op_i | input | 3 | 0 test, 1 extract-unsigned, 2 change, 3 extract-signed, 4 clear, 5 find-first-one, 6 set, 7 insert |
| base_i | input | 32 | Base byte address |
| off_i | input | 32 | Signed bit offset |
| wm1_i | input | 5 | Field width minus one |
| src_i | input | 32 | Insert source, low W bits used |
| mem_req_valid | output | 1 | Byte request valid |
| mem_req_ready | input | 1 | Byte request accepted |
| mem_req_write | output | 1 | 1 write beat, 0 read beat |
| mem_req_wint | output | 1 | Read beat will later be written |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Response pulse |
| mem_rsp_fault | input | 1 | Response is a fault |
| mem_rsp_data | input | 8 | Read data |
| done_o | output | 1 | Command completed |
| error_o | output | 1 | Command aborted by fault |
| result_o | output | 32 | Extract or search result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
The bench covers offsets that cross byte boundaries, negative offsets, full-width fields spanning five bytes, single-byte fields, and a find-first-one on an all-zero field. A wrong span count shows up as extra or missing beats. A wrong byte advance shows up as a wrong first address. Bit ordering errors show up as corrupted neighbour bits in memory. The fault cases cover a fault in the middle of a read and a write-intent fault on a read-only byte. A design that wrote early or committed flags on a fault would leave memory or flags changed. A non-modifying op on the same read-only byte must still complete, which shows that write-intent is only raised when it is needed.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int FW    = 32;
  localparam int WIN_W = 2 * FW;
  localparam int WB    = $clog2(FW) + 1;
  localparam int MAXB  = (FW + 7 + 7) / 8;
  localparam int IW    = $clog2(MAXB + 1);

  typedef enum logic [2:0] {
    OP_TST = 3'd0, OP_EXTU = 3'd1, OP_CHG = 3'd2, OP_EXTS = 3'd3,
    OP_CLR = 3'd4, OP_FFO  = 3'd5, OP_SET = 3'd6, OP_INS  = 3'd7
  } bf_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT, S_FIN
  } bf_state_e;

  function automatic logic op_modifies(input bf_op_e op);
    return (op == OP_CHG) || (op == OP_CLR) || (op == OP_SET) || (op == OP_INS);
  endfunction
endpackage

// File: rtl/bf_span.sv
module bf_span
  import bf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]      base,
  input  logic [FW-1:0]      bit_off,
  input  logic [WB-2:0]      wm1,
  output logic [AW-1:0]      first_addr,
  output logic [2:0]         boff,
  output logic [WB-1:0]      width,
  output logic [IW-1:0]      nbytes
);
  localparam int SW = WB + 1;

  always_comb begin
    width      = {1'b0, wm1} + WB'(1);
    boff       = bit_off[2:0];
    first_addr = base + AW'($signed(bit_off) >>> 3);
    nbytes     = IW'((SW'(boff) + SW'(width) + SW'(7)) >> 3);
  end
endmodule

// File: rtl/bf_window_alu.sv
module bf_window_alu
  import bf_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  input  logic [2:0]       boff,
  input  logic [WB-1:0]    width,
  input  bf_op_e           op,
  input  logic [FW-1:0]    src,
  input  logic [FW-1:0]    bit_off,
  output logic [WIN_W-1:0] new_win,
  output logic [FW-1:0]    result,
  output logic             flag_n,
  output logic             flag_z
);
  logic [WB-1:0]    sh;
  logic [FW-1:0]    mask_msb, fld, ins_msb, flagged;
  logic [WIN_W-1:0] m64, ins64;

  function automatic logic [WB-1:0] lead0(input logic [FW-1:0] v);
    logic [WB-1:0] cnt;
    cnt = WB'(FW);
    for (int i = 0; i < FW; i++)
      if (v[i]) cnt = WB'(FW - 1 - i);
    return cnt;
  endfunction

  always_comb begin
    sh       = WB'(FW) - width;
    mask_msb = {FW{1'b1}} << sh;
    fld      = FW'((win << boff) >> FW) & mask_msb;
    m64      = {mask_msb, {FW{1'b0}}} >> boff;
    ins_msb  = src << sh;
    ins64    = {ins_msb, {FW{1'b0}}} >> boff;
    flagged  = (op == OP_INS) ? ins_msb : fld;
    flag_n   = flagged[FW-1];
    flag_z   = (flagged == '0);

    unique case (op)
      OP_SET:  new_win = win | m64;
      OP_CLR:  new_win = win & ~m64;
      OP_CHG:  new_win = win ^ m64;
      OP_INS:  new_win = (win & ~m64) | ins64;
      default: new_win = win;
    endcase

    unique case (op)
      OP_EXTS: result = FW'($signed(fld) >>> sh);
      OP_FFO:  result = bit_off + FW'(lead0(fld | ~mask_msb));
      default: result = fld >> sh;
    endcase
  end
endmodule

// File: rtl/bfmem_seq.sv
module bfmem_seq
  import bf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] base_i,
  input  logic [31:0]   off_i,
  input  logic [4:0]    wm1_i,
  input  logic [31:0]   src_i,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic          mem_req_wint,
  output logic [AW-1:0] mem_req_addr,
  output logic [7:0]    mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_fault,
  input  logic [7:0]    mem_rsp_data,
  output logic          done_o,
  output logic          error_o,
  output logic [31:0]   result_o,
  output logic          flag_n_o,
  output logic          flag_z_o
);
  bf_state_e        state_q;
  bf_op_e           op_q;
  logic [AW-1:0]    base_q;
  logic [FW-1:0]    off_q, src_q;
  logic [WB-2:0]    wm1_q;
  logic [IW-1:0]    idx_q;
  logic [WIN_W-1:0] win_q;

  logic [AW-1:0]    first_addr;
  logic [2:0]       boff;
  logic [WB-1:0]    width;
  logic [IW-1:0]    nbytes;
  logic [WIN_W-1:0] new_win;
  logic [FW-1:0]    alu_res;
  logic             alu_n, alu_z, last_beat, modifies;

  bf_span #(.AW(AW)) span_i (
    .base(base_q), .bit_off(off_q), .wm1(wm1_q),
    .first_addr(first_addr), .boff(boff), .width(width), .nbytes(nbytes)
  );

  bf_window_alu alu_i (
    .win(win_q), .boff(boff), .width(width), .op(op_q), .src(src_q),
    .bit_off(off_q), .new_win(new_win), .result(alu_res),
    .flag_n(alu_n), .flag_z(alu_z)
  );

  assign last_beat     = (idx_q == nbytes - IW'(1));
  assign modifies      = op_modifies(op_q);
  assign mem_req_valid = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
  assign mem_req_write = (state_q == S_WR_REQ);
  assign mem_req_wint  = (state_q == S_RD_REQ) && modifies;
  assign mem_req_addr  = first_addr + AW'(idx_q);
  assign mem_req_wdata = new_win[WIN_W-1-8*idx_q -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= OP_TST;
      base_q   <= '0;
      off_q    <= '0;
      src_q    <= '0;
      wm1_q    <= '0;
      idx_q    <= '0;
      win_q    <= '0;
      done_o   <= 1'b0;
      error_o  <= 1'b0;
      result_o <= '0;
      flag_n_o <= 1'b0;
      flag_z_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      error_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          op_q    <= bf_op_e'(op_i);
          base_q  <= base_i;
          off_q   <= off_i;
          src_q   <= src_i;
          wm1_q   <= wm1_i;
          idx_q   <= '0;
          win_q   <= '0;
          state_q <= S_RD_REQ;
        end
        S_RD_REQ: if (mem_req_ready) state_q <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_fault) begin
            error_o <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            win_q[WIN_W-1-8*idx_q -: 8] <= mem_rsp_data;
            if (last_beat) begin
              idx_q   <= '0;
              state_q <= modifies ? S_WR_REQ : S_FIN;
            end else begin
              idx_q   <= idx_q + IW'(1);
              state_q <= S_RD_REQ;
            end
          end
        end
        S_WR_REQ: if (mem_req_ready) state_q <= S_WR_WAIT;
        S_WR_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_fault) begin
            error_o <= 1'b1;
            state_q <= S_IDLE;
          end else if (last_beat) begin
            state_q <= S_FIN;
          end else begin
            idx_q   <= idx_q + IW'(1);
            state_q <= S_WR_REQ;
          end
        end
        S_FIN: begin
          done_o   <= 1'b1;
          result_o <= alu_res;
          flag_n_o <= alu_n;
          flag_z_o <= alu_z;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // Request held under back-pressure
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_wint) && $stable(mem_req_wdata)));

  // Beat index stays inside the computed span
  assert_beat_in_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (idx_q < nbytes));

  // Write beats only for modifying operations
  assert_write_only_modify_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> op_modifies(op_q));

  // A fault leaves the committed outputs alone and never pairs with done
  assert_fault_no_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (!done_o && $stable(result_o) && $stable(flag_n_o) && $stable(flag_z_o)));

  // Write intent on reads follows the operation class
  assert_intent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> (mem_req_wint == op_modifies(op_q)));

  // Done is a single-cycle pulse
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/bfmem_seq_tb_top.sv
module bfmem_seq_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [31:0] base_i = '0, off_i = '0, src_i = '0;
  logic [4:0] wm1_i = '0;
  logic mem_req_valid, mem_req_write, mem_req_wint;
  logic mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [7:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0, mem_rsp_fault = 1'b0;
  logic [7:0] mem_rsp_data = '0;
  logic done_o, error_o, flag_n_o, flag_z_o;
  logic [31:0] result_o;

  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  bfmem_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .base_i(base_i),
    .off_i(off_i), .wm1_i(wm1_i), .src_i(src_i),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_wint(mem_req_wint),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_fault(mem_rsp_fault),
    .mem_rsp_data(mem_rsp_data), .done_o(done_o), .error_o(error_o),
    .result_o(result_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o)
  );

  // memory model
  logic [7:0] mem [64];
  logic [7:0] shadow [64];
  int fault_addr = -1, ro_addr = -1;
  logic clr_stats = 1'b0;
  int nrd, nwr, nwint, first_rd;
  logic order_bad;
  logic [7:0] lfsr = 8'hA5;

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= lfsr[0] | lfsr[3];
  end

  always @(posedge clk) begin
    logic f;
    int a;
    mem_rsp_valid <= 1'b0;
    mem_rsp_fault <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= (i >= 50 && i <= 54) ? 8'h00 : 8'(i * 37 + 11);
      nrd <= 0; nwr <= 0; nwint <= 0; first_rd <= -1; order_bad <= 1'b0;
    end else if (clr_stats) begin
      nrd <= 0; nwr <= 0; nwint <= 0; first_rd <= -1; order_bad <= 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      a = int'(mem_req_addr[5:0]);
      if (!mem_req_write) begin
        if (nrd == 0) first_rd <= int'(mem_req_addr);
        nrd <= nrd + 1;
        if (nwr != 0) order_bad <= 1'b1;
        if (mem_req_wint) nwint <= nwint + 1;
        f = (a == fault_addr) || (mem_req_wint && a == ro_addr);
        mem_rsp_data <= mem[a];
      end else begin
        nwr <= nwr + 1;
        f = (a == fault_addr) || (a == ro_addr);
        if (!f) mem[a] <= mem_req_wdata;
      end
      mem_rsp_valid <= 1'b1;
      mem_rsp_fault <= f;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit sbit(input int b);
    return shadow[b >> 3][7 - (b & 7)];
  endfunction

  task automatic shadow_put(input int b, input bit v);
    shadow[b >> 3][7 - (b & 7)] = v;
  endtask

  // returns 1 on done, 0 on error or timeout
  task automatic issue(input int op, input int base, input int off, input int wm1,
                       input logic [31:0] src, output bit got_done, output bit got_err);
    int n;
    @(negedge clk);
    op_i = 3'(op); base_i = base; off_i = off; wm1_i = 5'(wm1); src_i = src;
    start_i = 1'b1; clr_stats = 1'b1;
    @(negedge clk);
    start_i = 1'b0; clr_stats = 1'b0;
    got_done = 0; got_err = 0; n = 0;
    while (!got_done && !got_err && n < 500) begin
      if (done_o) got_done = 1;
      if (error_o) got_err = 1;
      if (!got_done && !got_err) begin @(negedge clk); n++; end
    end
    if (n >= 500) check(0, "watchdog", n, 0);
  endtask

  task automatic mem_match(input string req);
    int bad = -1;
    for (int i = 0; i < 64; i++) if (mem[i] !== shadow[i] && bad < 0) bad = i;
    check(bad < 0, req, bad < 0 ? 0 : mem[bad], bad < 0 ? 0 : shadow[bad]);
  endtask

  task automatic run_vec(input int op, input int base, input int off, input int wm1,
                         input logic [31:0] src, input int nb);
    int w, bb;
    logic [31:0] fv, er, fl;
    bit d, e, mod;
    w = wm1 + 1; bb = base * 8 + off;
    mod = (op == 2) || (op == 4) || (op == 6) || (op == 7);
    fv = '0;
    for (int i = 0; i < w; i++) fv = {fv[30:0], sbit(bb + i)};
    er = fv;
    if (op == 3 && w < 32 && fv[w-1]) er = fv | (32'hFFFF_FFFF << w);
    if (op == 5) begin
      int k = w;
      for (int i = w - 1; i >= 0; i--) if (sbit(bb + i)) k = i;
      er = 32'(off + k);
    end
    fl = (op == 7) ? ((w == 32) ? src : (src & ((32'h1 << w) - 1))) : fv;
    for (int i = 0; i < w; i++) begin
      case (op)
        6: shadow_put(bb + i, 1'b1);
        4: shadow_put(bb + i, 1'b0);
        2: shadow_put(bb + i, ~sbit(bb + i));
        7: shadow_put(bb + i, fl[w-1-i]);
        default: ;
      endcase
    end
    issue(op, base, off, wm1, src, d, e);
    check(d && !e, "R13 done", {d, e}, 2'b10);
    check(result_o == er, op == 3 ? "R4 result" : op == 5 ? "R5 result" : "R3 result", result_o, er);
    check(flag_n_o == fl[w-1], "R6 N", flag_n_o, fl[w-1]);
    check(flag_z_o == (fl == 0), "R6 Z", flag_z_o, fl == 0);
    check(first_rd == (bb >>> 3), "R1 first address", first_rd, bb >>> 3);
    check(nrd == nb, "R2 read beats", nrd, nb);
    check(nwr == (mod ? nb : 0), "R9 write beats", nwr, mod ? nb : 0);
    check(!order_bad, "R9 order", order_bad, 0);
    check(nwint == (mod ? nb : 0), "R11 intent", nwint, mod ? nb : 0);
    mem_match(op == 7 ? "R8 memory" : "R7 memory");
  endtask

  // {op, base, signed offset, wm1, src, expected byte count}
  typedef struct packed {
    logic [2:0] op; logic [7:0] base; logic [15:0] off;
    logic [4:0] wm1; logic [31:0] src; logic [2:0] nb;
  } vec_t;
  localparam vec_t VECS [12] = '{
    '{3'd1, 8'd20, 16'sd0,   5'd7,  32'h0,         3'd1},
    '{3'd1, 8'd20, 16'sd3,   5'd31, 32'h0,         3'd5},
    '{3'd3, 8'd20, 16'sd12,  5'd4,  32'h0,         3'd2},
    '{3'd5, 8'd20, -16'sd5,  5'd11, 32'h0,         3'd2},
    '{3'd6, 8'd24, 16'sd7,   5'd9,  32'h0,         3'd3},
    '{3'd4, 8'd24, 16'sd33,  5'd31, 32'h0,         3'd5},
    '{3'd2, 8'd30, -16'sd17, 5'd2,  32'h0,         3'd2},
    '{3'd7, 8'd28, 16'sd2,   5'd5,  32'h0000_002A, 3'd1},
    '{3'd7, 8'd28, 16'sd5,   5'd19, 32'hFFF8_0001, 3'd4},
    '{3'd0, 8'd16, 16'sd0,   5'd0,  32'h0,         3'd1},
    '{3'd5, 8'd50, 16'sd4,   5'd15, 32'h0,         3'd3},
    '{3'd3, 8'd40, 16'sd1,   5'd31, 32'h0,         3'd5}
  };

  initial begin
    bit d, e;
    logic [31:0] r0;
    logic n0, z0;
    for (int i = 0; i < 64; i++) shadow[i] = (i >= 50 && i <= 54) ? 8'h00 : 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    check(!mem_req_valid && !done_o && !error_o, "R13 reset idle",
          {mem_req_valid, done_o, error_o}, 0);
    check(result_o == 0 && !flag_n_o && !flag_z_o, "R13 reset outputs", result_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 12; v++)
      run_vec(int'(VECS[v].op), int'(VECS[v].base), int'($signed(VECS[v].off)),
              int'(VECS[v].wm1), VECS[v].src, int'(VECS[v].nb));

    // fault on the second read of a set
    r0 = result_o; n0 = flag_n_o; z0 = flag_z_o;
    fault_addr = 11;
    issue(6, 10, 4, 15, 32'h0, d, e);
    check(e && !d, "R10 error pulse", {d, e}, 2'b01);
    check(nrd == 2 && nwr == 0, "R10 beats stop", nrd * 16 + nwr, 32);
    check(result_o == r0 && flag_n_o == n0 && flag_z_o == z0, "R10 outputs kept", result_o, r0);
    mem_match("R10 memory");
    fault_addr = -1;

    // write-intent fault on a read-only byte
    ro_addr = 12;
    issue(4, 12, 0, 7, 32'h0, d, e);
    check(e && !d, "R11 intent fault", {d, e}, 2'b01);
    check(nwr == 0, "R11 no writes", nwr, 0);
    check(result_o == r0 && flag_n_o == n0 && flag_z_o == z0, "R10 flags kept", result_o, r0);
    mem_match("R11 memory");
    // non-modifying op on the same read-only byte completes
    run_vec(1, 12, 0, 7, 32'h0, 1);
    ro_addr = -1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule